// File: doc/BRIEF.md
# USB Frame Timer and Frame-List Address Generator

This block times USB frames from the 12 MHz bit clock and names, for every new frame, the system-memory word that holds that frame's schedule pointer. A down-counter runs once per bit time while the block is running. When the counter reaches zero, the next frame begins. A trim register sets the frame length in bit times. Software can therefore stretch or shrink frames while the block runs, so that the frame rate follows an isochronous stream.

An 11-bit frame number advances once per frame, and software may preset it while the block is stopped. The low ten bits of the frame number index a 1024-entry, 4 KB pointer table. The entry address is formed by concatenation only: the 4 KB-aligned table base supplies the upper 20 bits, the frame index fills bits 11:2, and bits 1:0 are zero. On the cycle after expiry the block raises a one-cycle start-of-frame pulse and a fetch request, and at that point the address already names the new entry. A small register port gives software access to the run control, the frame number, the table base and the trim value.

Top module: `usb_frame_timer`

## Requirements
- R1: After reset, sof_o and fetch_req_o are low, the frame number is 0, the run bit is 0, the base reads 0 and the trim register reads ADJ_DEFAULT (64).
- R2: While the block runs, SOF pulses are exactly FRAME_BASE + trim clocks apart. With the default values this is 11936 + 64 = 12000 clocks, which is 1 ms of bit time.
- R3: A trim write takes effect from the next frame boundary. The frame in progress keeps its length. A write captured on the same clock as the expiry leaves the frame that starts at that clock at the old length, and only the frame after it uses the new value.
- R4: sof_o is high for one cycle only. fetch_req_o is high in exactly the same cycles as sof_o.
- R5: Each SOF shows a frame number one higher than before. The number wraps from 2047 to 0.
- R6: fetch_addr_o equals {base[31:12], frame[9:0], 2'b00}. Because the frame index wraps from 1023 to 0, the address returns to the table base.
- R7: A write to the frame-number register while the block is stopped loads the counter, and reads return it. A write while the block is running is ignored.
- R8: While the block is stopped, the bit counter and the frame number hold and no SOF occurs.
- R9: Register map, selected by reg_addr_i: 0 is control (bit 0 = run); 1 is the frame number (bits 10:0); 2 is the base (bits 31:12, where low bits are dropped and read as 0); 3 is the trim (bits 7:0). Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 12 MHz bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| sof_o | output | 1 | One-cycle start-of-frame pulse |
| frame_num_o | output | 11 | Current frame number |
| fetch_req_o | output | 1 | Table-entry fetch strobe |
| fetch_addr_o | output | 32 | Byte address of current table entry |

## Verification
A trim write and a counter expiry can land on the same clock edge. The bench derives the expiry edge from the previous SOF and the known frame length, then drives the trim write so that it is captured on exactly that edge. It checks the three intervals that follow: the SOF must still appear on time, the next frame must keep the old length, and only the frame after that may use the new length.

// File: rtl/usbft_pkg.sv
package usbft_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_FNUM = 2'd1,
    REG_BASE = 2'd2,
    REG_ADJ  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/usbft_regs.sv
module usbft_regs import usbft_pkg::*; #(
  parameter int ADJ_W       = 8,
  parameter int ADJ_DEFAULT = 64,
  parameter int FN_W        = 11,
  parameter int BASE_W      = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [FN_W-1:0]   frame_num_i,
  output logic              run_o,
  output logic [ADJ_W-1:0]  adj_o,
  output logic [BASE_W-1:0] base_o,
  output logic              fn_load_o,
  output logic [FN_W-1:0]   fn_val_o
);
  localparam int LOW_W = 32 - BASE_W;

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o  <= 1'b0;
      adj_o  <= ADJ_W'(ADJ_DEFAULT);
      base_o <= '0;
    end else if (we_i) begin
      case (reg_sel_e'(addr_i))
        REG_CTRL: run_o  <= wdata_i[0];
        REG_BASE: base_o <= wdata_i[31:LOW_W];
        REG_ADJ:  adj_o  <= wdata_i[ADJ_W-1:0];
        default:  ;
      endcase
    end
  end

  // frame-number preset only honoured while stopped
  assign fn_load_o = we_i && (reg_sel_e'(addr_i) == REG_FNUM) && !run_o;
  assign fn_val_o  = wdata_i[FN_W-1:0];

  always_comb begin
    case (reg_sel_e'(addr_i))
      REG_CTRL: rdata_o = {31'd0, run_o};
      REG_FNUM: rdata_o = {{(32-FN_W){1'b0}}, frame_num_i};
      REG_BASE: rdata_o = {base_o, {LOW_W{1'b0}}};
      default:  rdata_o = {{(32-ADJ_W){1'b0}}, adj_o};
    endcase
  end
endmodule

// File: rtl/usbft_sof_timer.sv
module usbft_sof_timer #(
  parameter int CNT_W       = 16,
  parameter int ADJ_W       = 8,
  parameter int FRAME_BASE  = 11936,
  parameter int ADJ_DEFAULT = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [ADJ_W-1:0] adj_i,
  output logic             expire_o,
  output logic             sof_o
);
  localparam logic [CNT_W-1:0] RST_CNT = CNT_W'(FRAME_BASE + ADJ_DEFAULT - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] reload;

  assign reload   = CNT_W'(FRAME_BASE) + {{(CNT_W-ADJ_W){1'b0}}, adj_i} - 1'b1;
  assign expire_o = run_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= RST_CNT;
      sof_o <= 1'b0;
    end else begin
      sof_o <= expire_o;
      if (expire_o)   cnt_q <= reload;
      else if (run_i) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/usbft_frame_ctr.sv
module usbft_frame_ctr #(
  parameter int FN_W   = 11,
  parameter int IDX_W  = 10,
  parameter int BASE_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              expire_i,
  input  logic              load_i,
  input  logic [FN_W-1:0]   load_val_i,
  input  logic [BASE_W-1:0] base_i,
  output logic [FN_W-1:0]   frame_num_o,
  output logic              fetch_req_o,
  output logic [31:0]       fetch_addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_num_o <= '0;
      fetch_req_o <= 1'b0;
    end else begin
      fetch_req_o <= expire_i;
      if (load_i)        frame_num_o <= load_val_i;
      else if (expire_i) frame_num_o <= frame_num_o + 1'b1;
    end
  end

  // pure concatenation: base | index | word alignment
  generate
    if (BASE_W + IDX_W + 2 == 32) begin : g_addr
      assign fetch_addr_o = {base_i, frame_num_o[IDX_W-1:0], 2'b00};
    end else begin : g_addr_pad
      assign fetch_addr_o = 32'({base_i, frame_num_o[IDX_W-1:0], 2'b00});
    end
  endgenerate
endmodule

// File: rtl/usb_frame_timer.sv
module usb_frame_timer #(
  parameter int FRAME_BASE  = 11936,
  parameter int ADJ_W       = 8,
  parameter int ADJ_DEFAULT = 64,
  parameter int CNT_W       = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        sof_o,
  output logic [10:0] frame_num_o,
  output logic        fetch_req_o,
  output logic [31:0] fetch_addr_o
);
  localparam int FN_W   = 11;
  localparam int IDX_W  = FN_W - 1;
  localparam int BASE_W = 32 - IDX_W - 2;

  logic              run;
  logic [ADJ_W-1:0]  adj;
  logic [BASE_W-1:0] base;
  logic              fn_load;
  logic [FN_W-1:0]   fn_val;
  logic              expire;

  usbft_regs #(
    .ADJ_W(ADJ_W), .ADJ_DEFAULT(ADJ_DEFAULT), .FN_W(FN_W), .BASE_W(BASE_W)
  ) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .frame_num_i(frame_num_o),
    .run_o(run), .adj_o(adj), .base_o(base),
    .fn_load_o(fn_load), .fn_val_o(fn_val)
  );

  usbft_sof_timer #(
    .CNT_W(CNT_W), .ADJ_W(ADJ_W), .FRAME_BASE(FRAME_BASE), .ADJ_DEFAULT(ADJ_DEFAULT)
  ) u_timer (
    .clk_i, .rst_ni, .run_i(run), .adj_i(adj),
    .expire_o(expire), .sof_o(sof_o)
  );

  usbft_frame_ctr #(
    .FN_W(FN_W), .IDX_W(IDX_W), .BASE_W(BASE_W)
  ) u_fctr (
    .clk_i, .rst_ni, .expire_i(expire), .load_i(fn_load), .load_val_i(fn_val),
    .base_i(base), .frame_num_o(frame_num_o),
    .fetch_req_o(fetch_req_o), .fetch_addr_o(fetch_addr_o)
  );
endmodule

// File: rtl/usbft_chk.sv
module usbft_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        sof_o,
  input logic        fetch_req_o,
  input logic [31:0] fetch_addr_o,
  input logic [10:0] frame_num_o,
  input logic        run,
  input logic        fn_load
);
  a_r4_sof_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |=> !sof_o);

  a_r4_fetch_with_sof: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o == fetch_req_o);

  a_r5_frame_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> frame_num_o == $past(frame_num_o) + 11'd1);

  a_r6_addr_index: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_o |-> (fetch_addr_o[11:2] == frame_num_o[9:0]) && (fetch_addr_o[1:0] == 2'b00));

  a_r8_stop_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !fn_load) |=> $stable(frame_num_o));

  a_r8_no_sof_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> !sof_o);
endmodule

bind usb_frame_timer usbft_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sof_o(sof_o), .fetch_req_o(fetch_req_o),
  .fetch_addr_o(fetch_addr_o), .frame_num_o(frame_num_o),
  .run(run), .fn_load(fn_load)
);

// File: tb/usb_frame_timer_bench.sv
`timescale 1ns/1ps
module usb_frame_timer_bench;
  localparam int FB   = 200;
  localparam int ADEF = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        sof, freq;
  logic [10:0] fnum;
  logic [31:0] faddr;

  usb_frame_timer #(.FRAME_BASE(FB)) u_usb_frame_timer (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .sof_o(sof),
    .frame_num_o(fnum), .fetch_req_o(freq), .fetch_addr_o(faddr)
  );

  // default-parameter instance for the 12000-clock frame
  logic        we_d = 1'b0;
  logic [31:0] rdata_d, faddr_d;
  logic        sof_d, freq_d;
  logic [10:0] fnum_d;
  usb_frame_timer u_usb_frame_timer_dflt (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we_d), .reg_addr_i(2'd0),
    .reg_wdata_i(32'd1), .reg_rdata_o(rdata_d), .sof_o(sof_d),
    .frame_num_o(fnum_d), .fetch_req_o(freq_d), .fetch_addr_o(faddr_d)
  );

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  int dlast = -1;
  int dintv = -1;
  always @(negedge clk) if (sof_d) begin
    if (dlast >= 0 && dintv < 0) dintv = cyc - dlast;
    dlast = cyc;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(input logic [31:0] b, input logic [10:0] f);
    return {b[31:12], f[9:0], 2'b00};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wait_sof(output int c);
    int guard = 0;
    do begin
      @(negedge clk); guard++;
    end while (!sof && guard < 2000);
    if (!sof) chk(1'b0, "R2", "sof timeout", 0, 1);
    c = cyc;
  endtask

  initial begin
    logic [31:0] d, base;
    int c0, c1, c2, c3, len, nlen;
    logic [10:0] f;
    int seen;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sof == 1'b0 && freq == 1'b0, "R1", "sof/fetch at reset", {sof, freq}, 0);
    chk(fnum == 11'd0, "R1", "frame at reset", fnum, 0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd3, d); chk(d == ADEF, "R1", "trim default", d, ADEF);
    rd(2'd0, d); chk(d == 0, "R1", "run default", d, 0);
    rd(2'd2, d); chk(d == 0, "R1", "base default", d, 0);
    @(negedge clk); we_d = 1'b1; @(negedge clk); we_d = 1'b0;

    // R9 base low bits dropped
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, d); chk(d == 32'hFFFF_F000, "R9", "base readback", d, 32'hFFFF_F000);
    base = 32'hFFFF_F000;

    // R7 preload while stopped, R8 hold
    wr(2'd1, 32'd5);
    rd(2'd1, d); chk(d == 5, "R7", "preload readback", d, 5);
    seen = 0;
    for (int i = 0; i < 600; i++) begin @(negedge clk); if (sof) seen++; end
    chk(seen == 0, "R8", "sof while stopped", seen, 0);
    chk(fnum == 11'd5, "R8", "frame held while stopped", fnum, 5);

    // run: first SOF, address, default interval
    wr(2'd0, 32'd1);
    wait_sof(c0);
    chk(fnum == 11'd6, "R5", "first frame", fnum, 6);
    chk(freq == 1'b1, "R4", "fetch with sof", freq, 1);
    chk(faddr == exp_addr(base, 11'd6), "R6", "addr", faddr, exp_addr(base, 11'd6));
    @(negedge clk);
    chk(sof == 1'b0 && freq == 1'b0, "R4", "pulse width", {sof, freq}, 0);
    wait_sof(c1);
    chk(c1 - c0 == FB + ADEF, "R2", "default interval", c1 - c0, FB + ADEF);
    len = FB + ADEF;

    // R3 random trim values written mid-frame
    for (int k = 0; k < 3; k++) begin
      d = $urandom % 256;
      nlen = FB + int'(d);
      wr(2'd3, d);
      wait_sof(c2);
      chk(c2 - c1 == len, "R3", "frame in progress keeps length", c2 - c1, len);
      wait_sof(c3);
      chk(c3 - c2 == nlen, "R2", "trimmed interval", c3 - c2, nlen);
      len = nlen; c1 = c3;
    end

    // R3 trim write captured on the expiry edge
    nlen = FB + 7;
    repeat (len - 2) @(negedge clk);
    wr(2'd3, 32'd7);
    chk(sof == 1'b1, "R3", "sof on collision edge", sof, 1);
    c2 = cyc;
    chk(c2 - c1 == len, "R3", "collision frame length", c2 - c1, len);
    wait_sof(c3);
    chk(c3 - c2 == len, "R3", "frame after collision old length", c3 - c2, len);
    wait_sof(c0);
    chk(c0 - c3 == nlen, "R3", "new length one frame later", c0 - c3, nlen);

    // R7 write while running ignored
    rd(2'd1, d); f = d[10:0];
    wr(2'd1, {21'd0, f + 11'd100});
    rd(2'd1, d); chk(d[10:0] == f, "R7", "write while running ignored", d, f);

    // R6 index wrap with random base
    base = $urandom & 32'hFFFF_F000;
    wr(2'd0, 32'd0);
    wr(2'd1, 32'd1022);
    wr(2'd2, base);
    wr(2'd0, 32'd1);
    wait_sof(c0);
    chk(faddr == exp_addr(base, 11'd1023), "R6", "addr idx 1023", faddr, exp_addr(base, 11'd1023));
    wait_sof(c0);
    chk(fnum == 11'd1024, "R5", "frame 1024", fnum, 1024);
    chk(faddr == base, "R6", "addr wraps to base", faddr, base);

    // R5 counter wrap
    wr(2'd0, 32'd0);
    wr(2'd1, 32'd2046);
    wr(2'd0, 32'd1);
    wait_sof(c0);
    chk(fnum == 11'd2047, "R5", "frame 2047", fnum, 2047);
    chk(faddr == exp_addr(base, 11'd2047), "R6", "addr at 2047", faddr, exp_addr(base, 11'd2047));
    wait_sof(c0);
    chk(fnum == 11'd0, "R5", "wrap to 0", fnum, 0);
    chk(faddr == base, "R6", "addr at wrap", faddr, base);

    // R2 default parameters give 12000
    for (int i = 0; i < 40000 && dintv < 0; i++) @(negedge clk);
    chk(dintv == 12000, "R2", "default 1 ms frame", dintv, 12000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule